// File: doc/BRIEF.md
# Streaming Entropy Source Health Monitor

This block sits between a random event timestamp source and the conditioning generator that consumes its raw samples. Each valid sample is tested on arrival, in the same cycle, against the sample before it. The block looks for two gross failure patterns. One is a run of equal samples. The other is a run of samples that climb by exactly one, modulo two to the sample width. Both patterns appear when one physical event is captured several times. Small statistical bias is deliberately ignored. The goal is to catch a badly broken source, not to grade a good one.

A run that reaches the configured cutoff length (3 by default) sets a sticky alarm. The alarm stays set until a synchronous reset or a clear pulse. Every sample is forwarded one cycle later toward the downstream conditioner. Alongside it the block drives a per-sample pass strobe and a health qualifier, which stays low while the alarm is set. The raw samples are meant to go only to this monitor and to the conditioner, never directly to a consumer.

Top module: `entropy_health_monitor`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `alarm`, `out_valid`, `pass_strobe` and `out_healthy` are all 0.
- R2: A run of RUN_CUTOFF equal valid samples sets `alarm`. The alarm is visible in the cycle after the last sample of the run. Cycles with `in_valid` low do not break or extend a run, whatever `in_data` holds.
- R3: A run of RUN_CUTOFF valid samples, each exactly one above the previous modulo 2^SAMPLE_W, sets `alarm`. The step from 0xFFFF to 0x0000 counts as +1. Descending steps never count.
- R4: A run shorter than RUN_CUTOFF never sets `alarm`. Both run counts restart when their relation breaks, so alternating short runs (two equal, then a +1 step, then equal again) stay clean.
- R5: A sample that breaks one relation restarts that run even if it continues the other. The equal run and the step run are tracked independently.
- R6: `alarm` is sticky. A one-cycle `clr_alarm` pulse clears it from the next cycle and also discards the sample history, so the first sample after the clear starts a new run of length 1.
- R7: `out_valid` and `out_data` repeat `in_valid` and `in_data` with one cycle of registered delay.
- R8: `pass_strobe` is 1 in the cycle after a valid sample that did not complete a failing run. It is 0 after the sample that completes one, and 0 after cycles with no valid sample.
- R9: `out_healthy` is 1 only alongside a forwarded sample, and only when the alarm is not set after that sample. Once the alarm is set it stays 0 for every forwarded sample until a clear, even for samples that pass.
- R10: The cutoff is the parameter RUN_CUTOFF (at least 2). With RUN_CUTOFF = 5, four equal samples leave `alarm` at 0 and a fifth sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_alarm | input | 1 | Clears the alarm and the sample history |
| in_valid | input | 1 | Qualifies `in_data` |
| in_data | input | SAMPLE_W | Raw timestamp sample |
| alarm | output | 1 | Sticky gross-failure flag |
| pass_strobe | output | 1 | Previous-cycle sample passed both run tests |
| out_valid | output | 1 | Forwarded sample valid |
| out_data | output | SAMPLE_W | Forwarded sample |
| out_healthy | output | 1 | Forwarded sample is usable (alarm clear) |

## Verification
The bench builds two copies that share all inputs. The first uses the default 16-bit width and a cutoff of 3. With it, the 0xFFFF to 0x0000 wrap of the step test can be reached directly, and a full failing run takes only three samples. The second copy keeps the width but uses a cutoff of 5. It shows that the run length at which a pattern fails follows the parameter: four equal samples stay clean where the first copy has already alarmed.

// File: rtl/ehm_pkg.sv
package ehm_pkg;

   typedef enum logic [0:0] {
      REL_REPEAT = 1'b0,
      REL_STEP   = 1'b1
   } rel_kind_e;

   localparam int NUM_RELATIONS = 2;

   function automatic rel_kind_e kind_of(input int idx);
      return (idx == 0) ? REL_REPEAT : REL_STEP;
   endfunction

endpackage

// File: rtl/ehm_history.sv
module ehm_history #(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                forget,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_data,
   output logic [SAMPLE_W-1:0] prev_data,
   output logic                prev_valid
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_data  <= '0;
         prev_valid <= 1'b0;
      end else if (in_valid) begin
         prev_data  <= in_data;
         prev_valid <= 1'b1;
      end else if (forget) begin
         prev_valid <= 1'b0;
      end
   end

   assert_forget_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (forget && !in_valid) |=> !prev_valid);

endmodule

// File: rtl/ehm_run_tracker.sv
module ehm_run_tracker
   import ehm_pkg::*;
#(
   parameter int        SAMPLE_W   = 16,
   parameter int        RUN_CUTOFF = 3,
   parameter rel_kind_e KIND       = REL_REPEAT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_data,
   input  logic [SAMPLE_W-1:0] prev_data,
   input  logic                prev_valid,
   output logic                trip
);

   localparam int CW = $clog2(RUN_CUTOFF + 1);
   localparam logic [CW:0]       LIMIT = RUN_CUTOFF[CW:0];
   localparam logic [SAMPLE_W-1:0] ONE = {{(SAMPLE_W-1){1'b0}}, 1'b1};

   logic          rel_hit;
   logic          link;
   logic [CW-1:0] run_cnt;
   logic [CW:0]   run_inc;

   generate
      if (KIND == REL_REPEAT) begin : g_repeat
         assign rel_hit = (in_data == prev_data);
      end else begin : g_step
         assign rel_hit = (in_data == (prev_data + ONE));
      end
   endgenerate

   assign link    = prev_valid && rel_hit;
   assign run_inc = {1'b0, run_cnt} + {{CW{1'b0}}, 1'b1};
   assign trip    = in_valid && link && (run_inc >= LIMIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (in_valid) begin
         if (!link)
            run_cnt <= CW'(1);
         else if (run_inc >= LIMIT)
            run_cnt <= LIMIT[CW-1:0];
         else
            run_cnt <= run_inc[CW-1:0];
      end else if (restart) begin
         run_cnt <= '0;
      end
   end

   assert_run_bound_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= LIMIT[CW-1:0]);

   assert_idle_hold_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !restart) |=> $stable(run_cnt));

   assert_break_restart_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !link) |=> (run_cnt == CW'(1)));

endmodule

// File: rtl/ehm_alarm_ctrl.sv
module ehm_alarm_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic any_trip,
   output logic alarm_next,
   output logic alarm
);

   assign alarm_next = any_trip | (alarm & ~clr);

   always_ff @(posedge clk) begin
      if (!rst_n) alarm <= 1'b0;
      else        alarm <= alarm_next;
   end

   assert_alarm_sticky_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (alarm && !clr) |=> alarm);

   assert_alarm_cause_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm && !any_trip) |=> !alarm);

endmodule

// File: rtl/ehm_forward_stage.sv
module ehm_forward_stage #(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_data,
   input  logic                any_trip,
   input  logic                alarm_next,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_data,
   output logic                pass_strobe,
   output logic                out_healthy
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_data    <= '0;
         pass_strobe <= 1'b0;
         out_healthy <= 1'b0;
      end else begin
         out_valid   <= in_valid;
         pass_strobe <= in_valid & ~any_trip;
         out_healthy <= in_valid & ~alarm_next;
         if (in_valid) out_data <= in_data;
      end
   end

   assert_fwd_delay_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_valid && out_data == $past(in_data)));

   assert_pass_needs_valid_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      pass_strobe |-> out_valid);

endmodule

// File: rtl/entropy_health_monitor.sv
module entropy_health_monitor
   import ehm_pkg::*;
#(
   parameter int SAMPLE_W   = 16,
   parameter int RUN_CUTOFF = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr_alarm,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_data,
   output logic                alarm,
   output logic                pass_strobe,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_data,
   output logic                out_healthy
);

   generate
      if (SAMPLE_W < 2) begin : g_bad_width
         $error("SAMPLE_W must be at least 2");
      end
      if (RUN_CUTOFF < 2) begin : g_bad_cutoff
         $error("RUN_CUTOFF must be at least 2");
      end
   endgenerate

   logic [SAMPLE_W-1:0]      prev_data;
   logic                     prev_valid;
   logic                     eff_prev_valid;
   logic [NUM_RELATIONS-1:0] trip_vec;
   logic                     any_trip;
   logic                     alarm_next;

   ehm_history #(.SAMPLE_W(SAMPLE_W)) u_history (
      .clk        (clk),
      .rst_n      (rst_n),
      .forget     (clr_alarm),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .prev_data  (prev_data),
      .prev_valid (prev_valid)
   );

   assign eff_prev_valid = prev_valid & ~clr_alarm;

   generate
      for (genvar k = 0; k < NUM_RELATIONS; k++) begin : g_rel
         ehm_run_tracker #(
            .SAMPLE_W   (SAMPLE_W),
            .RUN_CUTOFF (RUN_CUTOFF),
            .KIND       (kind_of(k))
         ) u_tracker (
            .clk        (clk),
            .rst_n      (rst_n),
            .restart    (clr_alarm),
            .in_valid   (in_valid),
            .in_data    (in_data),
            .prev_data  (prev_data),
            .prev_valid (eff_prev_valid),
            .trip       (trip_vec[k])
         );
      end
   endgenerate

   assign any_trip = |trip_vec;

   ehm_alarm_ctrl u_alarm (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr_alarm),
      .any_trip   (any_trip),
      .alarm_next (alarm_next),
      .alarm      (alarm)
   );

   ehm_forward_stage #(.SAMPLE_W(SAMPLE_W)) u_forward (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_data     (in_data),
      .any_trip    (any_trip),
      .alarm_next  (alarm_next),
      .out_valid   (out_valid),
      .out_data    (out_data),
      .pass_strobe (pass_strobe),
      .out_healthy (out_healthy)
   );

   assert_healthy_implies_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      out_healthy |-> (pass_strobe && out_valid && !alarm));

   assert_trip_blocks_pass_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm) |-> !pass_strobe);

endmodule

// File: tb/entropy_health_monitor_bench.sv
module entropy_health_monitor_bench;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         clr_alarm;
   logic         in_valid;
   logic [W-1:0] in_data;

   logic         alarm, pass_strobe, out_valid, out_healthy;
   logic [W-1:0] out_data;
   logic         alarm5, pass5, ov5, oh5;
   logic [W-1:0] od5;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   entropy_health_monitor #(.SAMPLE_W(W), .RUN_CUTOFF(3)) u_entropy_health_monitor (
      .clk(clk), .rst_n(rst_n), .clr_alarm(clr_alarm),
      .in_valid(in_valid), .in_data(in_data),
      .alarm(alarm), .pass_strobe(pass_strobe), .out_valid(out_valid),
      .out_data(out_data), .out_healthy(out_healthy)
   );

   entropy_health_monitor #(.SAMPLE_W(W), .RUN_CUTOFF(5)) u_entropy_health_monitor_c5 (
      .clk(clk), .rst_n(rst_n), .clr_alarm(clr_alarm),
      .in_valid(in_valid), .in_data(in_data),
      .alarm(alarm5), .pass_strobe(pass5), .out_valid(ov5),
      .out_data(od5), .out_healthy(oh5)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive one valid sample, then sample outputs at the following negedge
   task automatic send(input logic [W-1:0] d);
      in_valid = 1'b1;
      in_data  = d;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic idle(input logic [W-1:0] junk);
      in_valid = 1'b0;
      in_data  = junk;
      @(negedge clk);
   endtask

   task automatic expect_out(input string req, input logic [W-1:0] d,
                             input logic ps, input logic al, input logic hl);
      check({req, " out_valid"},   32'(out_valid),   32'(1'b1));
      check({req, " out_data"},    32'(out_data),    32'(d));
      check({req, " pass_strobe"}, 32'(pass_strobe), 32'(ps));
      check({req, " alarm"},       32'(alarm),       32'(al));
      check({req, " out_healthy"}, 32'(out_healthy), 32'(hl));
   endtask

   task automatic do_clear();
      clr_alarm = 1'b1;
      in_valid  = 1'b0;
      @(negedge clk);
      clr_alarm = 1'b0;
      check("R6 clear drops alarm", 32'(alarm), 32'(1'b0));
      check("R6 clear drops alarm c5", 32'(alarm5), 32'(1'b0));
   endtask

   task automatic t_reset();
      rst_n = 1'b0; clr_alarm = 1'b0; in_valid = 1'b1; in_data = 16'h1111;
      repeat (3) @(negedge clk);
      check("R1 alarm in reset", 32'(alarm), 0);
      check("R1 out_valid in reset", 32'(out_valid), 0);
      check("R1 pass in reset", 32'(pass_strobe), 0);
      check("R1 healthy in reset", 32'(out_healthy), 0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 alarm after reset", 32'(alarm), 0);
      check("R1 out_valid after reset", 32'(out_valid), 0);
   endtask

   task automatic t_repeat_run();
      send(16'h1234); expect_out("R2 s1", 16'h1234, 1, 0, 1);
      idle(16'hBEEF);
      check("R7 idle out_valid", 32'(out_valid), 0);
      check("R8 idle pass", 32'(pass_strobe), 0);
      check("R9 idle healthy", 32'(out_healthy), 0);
      send(16'h1234); expect_out("R2 s2", 16'h1234, 1, 0, 1);
      idle(16'h1235);
      send(16'h1234); expect_out("R2 s3 trips", 16'h1234, 0, 1, 0);
      check("R10 c5 quiet at 3", 32'(alarm5), 0);
      repeat (3) idle(16'h0000);
      check("R6 sticky", 32'(alarm), 1);
      send(16'h0500); expect_out("R9 pass but unhealthy", 16'h0500, 1, 1, 0);
      do_clear();
   endtask

   task automatic t_step_wrap();
      send(16'hFFFE); expect_out("R3 w1", 16'hFFFE, 1, 0, 1);
      send(16'hFFFF); expect_out("R3 w2", 16'hFFFF, 1, 0, 1);
      send(16'h0000); expect_out("R3 wrap trips", 16'h0000, 0, 1, 0);
      do_clear();
      send(16'h0010); send(16'h000F); send(16'h000E);
      check("R3 descending ignored", 32'(alarm), 0);
      check("R3 descending pass", 32'(pass_strobe), 1);
      do_clear();
   endtask

   task automatic t_short_runs();
      send(16'h0005); send(16'h0005);
      send(16'h0006); send(16'h0006);
      send(16'h0009); send(16'h0009);
      send(16'h000A); send(16'h000A);
      check("R4 short runs no alarm", 32'(alarm), 0);
      check("R5 independent restart pass", 32'(pass_strobe), 1);
      check("R9 healthy while clean", 32'(out_healthy), 1);
      send(16'h000B); send(16'h000C);
      check("R4 step run of 3 trips", 32'(alarm), 1);
      do_clear();
   endtask

   task automatic t_clear_history();
      send(16'h0040); send(16'h0040);
      check("R6 pre-clear pass", 32'(pass_strobe), 1);
      do_clear();
      send(16'h0040);
      check("R6 fresh run after clear", 32'(alarm), 0);
      check("R6 fresh run pass", 32'(pass_strobe), 1);
      send(16'h0040);
      check("R6 run of two after clear", 32'(alarm), 0);
      send(16'h0040);
      check("R6 third after clear trips", 32'(alarm), 1);
      do_clear();
   endtask

   task automatic t_cutoff5();
      for (int i = 0; i < 4; i++) begin
         send(16'h0077);
         check("R10 c5 no alarm below cutoff", 32'(alarm5), 0);
      end
      send(16'h0077);
      check("R10 c5 alarm at cutoff", 32'(alarm5), 1);
      check("R10 c5 pass low at cutoff", 32'(pass5), 0);
      check("R10 c5 forwarded", 32'(od5), 32'h0077);
      do_clear();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      in_valid = 1'b0; in_data = '0; clr_alarm = 1'b0; rst_n = 1'b0;
      @(negedge clk);
      t_reset();
      t_repeat_run();
      t_step_wrap();
      t_short_runs();
      t_clear_history();
      t_cutoff5();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule